// File: doc/BRIEF.md
# Seconds RTC with shadowed readout

This block keeps wall-clock time as a free-running seconds count and a milliseconds count. A prescaler models a 32 kHz timebase from the system clock. Software reaches it through a small memory-mapped register bus with single-cycle requests. Reading the milliseconds register also captures the current seconds into a shadow register. Software reads milliseconds first and then the shadow, and so gets a seconds/milliseconds pair that belongs together even if a second rolls over between the two reads.

Once in every eight timebase periods the block raises a busy flag for one whole period. This is the window in which the counters are posted to the bus side. Register writes that arrive while busy is high are dropped. Reads are served at any time. A seconds compare alarm sets a sticky status bit. The status bits are qualified by a mask register and drive a level-sensitive, active-high interrupt line. Status bits are cleared by writing ones to them.

Top module: `sec_rtc`

## Requirements
- R1: After the asynchronous reset is released, every register reads zero, the busy bit reads 0 and irq_o is low.
- R2: The milliseconds register (offset 0x010) counts 0..MS_PER_S-1, advancing once per SLOW_DIV*SLOW_PER_MS clock edges. When it wraps from MS_PER_S-1 to 0, the seconds register (offset 0x008) advances by one.
- R3: Bit 0 of offset 0x004 is the busy flag. With k the number of timebase periods (SLOW_DIV clock edges each) since reset, it is high exactly when k mod 8 equals 7. The upper bits read 0.
- R4: A read of offset 0x010 loads the shadow register (offset 0x00c) with the seconds value at that moment. The shadow keeps that value until the next milliseconds read, even when seconds is written.
- R5: Writes to seconds (0x008), alarm (0x014), mask (0x028) and status (0x02c) take effect at the next edge when busy is low. A write issued while busy is high changes nothing.
- R6: Alarm register 0x014 holds a seconds compare value, and zero disables it. Status bit 0 sets on the first cycle the seconds count equals a nonzero alarm value.
- R7: Status (0x02c, bit 0 = seconds alarm) is write-one-to-clear. Written zeros leave bits unchanged, and a set bit stays set until cleared.
- R8: Mask (0x028) stores 5 bits (bit 0 seconds alarm; bits 1..4 reserved alarm sources) and reads back zero-extended. irq_o is high while any status bit and its mask bit are both 1.
- R9: Read data appears on bus_rdata_o with bus_rvalid_o high one clock after the request is sampled. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus request, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, registered |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The bench keeps an edge-count model of time and predicts the counters and the busy window from it. It then reads straight across the milliseconds-to-seconds rollover, where a carry taken one edge early or late shows up as a wrong seconds value. It issues writes inside the busy window and reads the targets back: a design that fails to gate these writes returns the written value instead of the old one. It checks that the shadow keeps its value across a seconds write, which catches a shadow that follows seconds directly. It writes zero to a set status bit, which catches clear-on-any-write logic. It clears the alarm status while the compare still matches, which catches an alarm that sets again on every matching cycle instead of only on the first.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned IRQ_W = 5;

  localparam logic [7:0] OFS_BUSY   = 8'h04;
  localparam logic [7:0] OFS_SEC    = 8'h08;
  localparam logic [7:0] OFS_SHADOW = 8'h0c;
  localparam logic [7:0] OFS_MS     = 8'h10;
  localparam logic [7:0] OFS_ALARM  = 8'h14;
  localparam logic [7:0] OFS_MASK   = 8'h28;
  localparam logic [7:0] OFS_STATUS = 8'h2c;

  localparam int unsigned IRQ_SEC_ALARM = 0;

  function automatic int unsigned cnt_w(int unsigned modulus);
    return (modulus > 1) ? $clog2(modulus) : 1;
  endfunction
endpackage

// File: rtl/rtc_modcnt.sv
module rtc_modcnt #(
  parameter int unsigned MOD = 8,
  localparam int unsigned W = rtc_pkg::cnt_w(MOD)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         at_max;

  assign at_max = (cnt_q == W'(MOD - 1));
  assign wrap_o = en_i && at_max;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (en_i)  cnt_q <= at_max ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int unsigned SLOW_DIV    = 4,
  parameter int unsigned SLOW_PER_MS = 4,
  parameter int unsigned POST_PERIOD = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ms_tick_o,
  output logic busy_o
);
  localparam int unsigned DIV_W  = rtc_pkg::cnt_w(SLOW_DIV);
  localparam int unsigned PH_W   = rtc_pkg::cnt_w(SLOW_PER_MS);
  localparam int unsigned POST_W = rtc_pkg::cnt_w(POST_PERIOD);

  logic              slow_tick;
  logic [DIV_W-1:0]  div_cnt;
  logic [PH_W-1:0]   ph_cnt;
  logic [POST_W-1:0] post_cnt;
  logic              post_wrap;

  // timebase period (one 32 kHz cycle equivalent)
  rtc_modcnt #(.MOD(SLOW_DIV)) u_div (
    .clk_i, .rst_ni, .en_i(1'b1), .cnt_o(div_cnt), .wrap_o(slow_tick)
  );

  rtc_modcnt #(.MOD(SLOW_PER_MS)) u_ms_phase (
    .clk_i, .rst_ni, .en_i(slow_tick), .cnt_o(ph_cnt), .wrap_o(ms_tick_o)
  );

  // posting window: last timebase period of each group
  rtc_modcnt #(.MOD(POST_PERIOD)) u_post (
    .clk_i, .rst_ni, .en_i(slow_tick), .cnt_o(post_cnt), .wrap_o(post_wrap)
  );

  assign busy_o = (post_cnt == POST_W'(POST_PERIOD - 1));

  AST_BUSY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slow_tick |=> $stable(busy_o)); // R3
  AST_BUSY_FALLS_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && post_wrap) |=> !busy_o); // R3
endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt #(
  parameter int unsigned MS_PER_S = 1000,
  parameter int unsigned SEC_W    = 32,
  localparam int unsigned MS_W    = rtc_pkg::cnt_w(MS_PER_S)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ms_tick_i,
  input  logic             sec_we_i,
  input  logic [SEC_W-1:0] sec_wdata_i,
  output logic [MS_W-1:0]  ms_o,
  output logic [SEC_W-1:0] sec_o
);
  logic             ms_wrap;
  logic [SEC_W-1:0] sec_q;

  rtc_modcnt #(.MOD(MS_PER_S)) u_ms (
    .clk_i, .rst_ni, .en_i(ms_tick_i), .cnt_o(ms_o), .wrap_o(ms_wrap)
  );

  // software load wins over a same-edge carry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sec_q <= '0;
    else if (sec_we_i) sec_q <= sec_wdata_i;
    else if (ms_wrap)  sec_q <= sec_q + 1'b1;
  end

  assign sec_o = sec_q;

  AST_MS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_o <= MS_W'(MS_PER_S - 1)); // R2
  AST_MS_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ms_tick_i && ms_o == MS_W'(MS_PER_S - 1) && !sec_we_i)
      |=> (ms_o == '0 && sec_o == $past(sec_o) + 1'b1)); // R2
  AST_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ms_tick_i && !sec_we_i) |=> $stable(sec_o)); // R2
  AST_SEC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_we_i |=> sec_o == $past(sec_wdata_i)); // R5
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned IRQ_W = rtc_pkg::IRQ_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEC_W-1:0] sec_i,
  input  logic             alarm_we_i,
  input  logic             mask_we_i,
  input  logic             stat_we_i,
  input  logic [SEC_W-1:0] wdata_i,
  output logic [SEC_W-1:0] alarm_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic [IRQ_W-1:0] status_o,
  output logic             irq_o
);
  logic [SEC_W-1:0] alarm_q;
  logic [IRQ_W-1:0] mask_q, status_q, status_d, evt;
  logic             match, match_q;

  assign match = (alarm_q != '0) && (sec_i == alarm_q);

  // only the seconds alarm source exists; others stay idle
  always_comb begin
    evt = '0;
    evt[rtc_pkg::IRQ_SEC_ALARM] = match && !match_q;
    for (int i = 0; i < int'(IRQ_W); i++)
      status_d[i] = evt[i] | (status_q[i] & ~(stat_we_i & wdata_i[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q  <= '0;
      mask_q   <= '0;
      status_q <= '0;
      match_q  <= 1'b0;
    end else begin
      if (alarm_we_i) alarm_q <= wdata_i;
      if (mask_we_i)  mask_q  <= wdata_i[IRQ_W-1:0];
      status_q <= status_d;
      match_q  <= match;
    end
  end

  assign alarm_o  = alarm_q;
  assign mask_o   = mask_q;
  assign status_o = status_q;
  assign irq_o    = |(status_q & mask_q);

  AST_ALARM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !match_q) |=> status_o[0]); // R6
  AST_ALARM_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o == '0 && !status_o[0]) |=> !status_o[0]); // R6
  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !(stat_we_i && wdata_i[0])) |=> status_o[0]); // R7
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SLOW_DIV    = 4,
  parameter int unsigned SLOW_PER_MS = 4,
  parameter int unsigned MS_PER_S    = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              irq_o
);
  import rtc_pkg::*;

  localparam int unsigned MS_W = cnt_w(MS_PER_S);

  logic              ms_tick, busy;
  logic [MS_W-1:0]   ms;
  logic [DATA_W-1:0] sec, alarm, shadow_q, rd_mux, rdata_q;
  logic [IRQ_W-1:0]  mask, status;
  logic              wr_ok, rd_req, rd_ms, rvalid_q;
  logic              sel_sec, sel_alarm, sel_mask, sel_stat;

  assign wr_ok  = bus_req_i && bus_we_i && !busy;
  assign rd_req = bus_req_i && !bus_we_i;
  assign rd_ms  = rd_req && (bus_addr_i == ADDR_W'(OFS_MS));

  assign sel_sec   = wr_ok && (bus_addr_i == ADDR_W'(OFS_SEC));
  assign sel_alarm = wr_ok && (bus_addr_i == ADDR_W'(OFS_ALARM));
  assign sel_mask  = wr_ok && (bus_addr_i == ADDR_W'(OFS_MASK));
  assign sel_stat  = wr_ok && (bus_addr_i == ADDR_W'(OFS_STATUS));

  rtc_tick_gen #(
    .SLOW_DIV(SLOW_DIV), .SLOW_PER_MS(SLOW_PER_MS), .POST_PERIOD(8)
  ) u_tick (
    .clk_i, .rst_ni, .ms_tick_o(ms_tick), .busy_o(busy)
  );

  rtc_time_cnt #(.MS_PER_S(MS_PER_S), .SEC_W(DATA_W)) u_time (
    .clk_i, .rst_ni, .ms_tick_i(ms_tick), .sec_we_i(sel_sec),
    .sec_wdata_i(bus_wdata_i), .ms_o(ms), .sec_o(sec)
  );

  rtc_irq_ctrl #(.SEC_W(DATA_W), .IRQ_W(IRQ_W)) u_irq (
    .clk_i, .rst_ni, .sec_i(sec),
    .alarm_we_i(sel_alarm), .mask_we_i(sel_mask), .stat_we_i(sel_stat),
    .wdata_i(bus_wdata_i), .alarm_o(alarm), .mask_o(mask),
    .status_o(status), .irq_o
  );

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr_i)
      ADDR_W'(OFS_BUSY):   rd_mux = DATA_W'(busy);
      ADDR_W'(OFS_SEC):    rd_mux = sec;
      ADDR_W'(OFS_SHADOW): rd_mux = shadow_q;
      ADDR_W'(OFS_MS):     rd_mux = DATA_W'(ms);
      ADDR_W'(OFS_ALARM):  rd_mux = alarm;
      ADDR_W'(OFS_MASK):   rd_mux = DATA_W'(mask);
      ADDR_W'(OFS_STATUS): rd_mux = DATA_W'(status);
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q  <= rd_mux;
      if (rd_ms)  shadow_q <= sec;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;

  AST_SHADOW_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ms |=> shadow_q == $past(sec)); // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_ms |=> $stable(shadow_q)); // R4
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && busy) |=> ($stable(alarm) && $stable(mask))); // R5
  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> bus_rvalid_o); // R9
  AST_NO_STRAY_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !bus_rvalid_o); // R9
endmodule

// File: tb/sec_rtc_tb_top.sv
module sec_rtc_tb_top;
  localparam int SD = 4, SPM = 4, MSPS = 1000;
  localparam longint EDGES_PER_MS = SD * SPM;
  localparam longint EDGES_PER_S  = EDGES_PER_MS * MSPS;

  localparam logic [7:0] A_BUSY = 8'h04, A_SEC = 8'h08, A_SHD = 8'h0c, A_MS = 8'h10;
  localparam logic [7:0] A_ALM = 8'h14, A_MSK = 8'h28, A_STA = 8'h2c, A_NONE = 8'h20;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, irq;

  sec_rtc #(.SLOW_DIV(SD), .SLOW_PER_MS(SPM), .MS_PER_S(MSPS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_rvalid_o(rvalid), .irq_o(irq)
  );

  always #2.5ns clk = ~clk;

  longint n_edges = 0;
  always @(posedge clk) if (rst_n) n_edges++;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  // reference model
  logic [31:0] sec_base = '0;
  longint      sec_ref  = 0;
  logic [31:0] shadow_m = '0, alarm_m = '0, mask_m = '0;

  function automatic logic [31:0] ms_at(longint n);
    return 32'((n / EDGES_PER_MS) % MSPS);
  endfunction
  function automatic logic [31:0] busy_at(longint n);
    return (((n / SD) % 8) == 7) ? 32'd1 : 32'd0;
  endfunction
  function automatic logic [31:0] sec_at(longint n);
    return sec_base + 32'(n / EDGES_PER_S - sec_ref / EDGES_PER_S);
  endfunction
  function automatic logic [31:0] exp_for(logic [7:0] a, longint n);
    case (a)
      A_BUSY:  return busy_at(n);
      A_SEC:   return sec_at(n);
      A_SHD:   return shadow_m;
      A_MS:    return ms_at(n);
      A_ALM:   return alarm_m;
      A_MSK:   return mask_m;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (sb_q.size() == 0) chk("R9 stray rvalid", 32'd1, 32'd0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        chk(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic issue_rd(logic [7:0] a, logic [31:0] e, string tag);
    item_t it;
    req = 1'b1; we = 1'b0; addr = a;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1ns req = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    logic [31:0] e;
    @(negedge clk);
    e = exp_for(a, n_edges);
    if (a == A_MS) shadow_m = sec_at(n_edges);
    issue_rd(a, e, tag);
  endtask

  task automatic rd_exp(logic [7:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    issue_rd(a, e, tag);
  endtask

  task automatic drive_wr(logic [7:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1ns req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    while (busy_at(n_edges) != 0) @(negedge clk);
    case (a)
      A_SEC: begin sec_base = d; sec_ref = n_edges + 1; end
      A_ALM: alarm_m = d;
      A_MSK: mask_m = d & 32'h1f;
      default: ;
    endcase
    drive_wr(a, d);
  endtask

  task automatic wr_busy(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    while (busy_at(n_edges) == 0) @(negedge clk);
    drive_wr(a, d);
  endtask

  task automatic wait_to(longint n);
    @(negedge clk);
    while (n_edges < n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #900us;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq after reset", 32'(irq), 32'd0);
    rd(A_SEC,  "R1 seconds reset");
    rd(A_SHD,  "R1 shadow reset");
    rd(A_MS,   "R1 ms reset");
    rd(A_ALM,  "R1 alarm reset");
    rd(A_MSK,  "R1 mask reset");
    rd_exp(A_STA, 32'd0, "R1 status reset");
    rd(A_BUSY, "R1 busy reset");
    rd_exp(A_NONE, 32'd0, "R9 unmapped offset");

    for (int i = 0; i < 48; i++) rd(A_BUSY, "R3 busy window");
    for (int i = 0; i < 24; i++) begin
      rd(A_MS, "R2 ms count");
      repeat (5) @(negedge clk);
    end

    // carry into seconds
    wait_to(EDGES_PER_S - 12);
    for (int i = 0; i < 12; i++) begin
      rd(A_SEC, "R2 seconds carry");
      rd(A_MS,  "R2 ms wrap");
    end
    rd_exp(A_STA, 32'd0, "R6 zero alarm disabled");

    // shadow
    rd(A_MS,  "R4 ms read");
    rd(A_SHD, "R4 shadow capture");
    wr(A_SEC, 32'd100);
    rd(A_SEC, "R5 seconds written");
    rd(A_SHD, "R4 shadow holds over write");
    rd(A_MS,  "R4 ms read 2");
    rd(A_SHD, "R4 shadow recapture");

    // busy drops writes
    wr_busy(A_ALM, 32'h55);
    rd(A_ALM, "R5 alarm write in busy");
    wr_busy(A_MSK, 32'h1f);
    rd(A_MSK, "R5 mask write in busy");
    wr_busy(A_SEC, 32'd7);
    rd(A_SEC, "R5 seconds write in busy");

    wr(A_MSK, 32'hffff_ffff);
    rd(A_MSK, "R8 mask width");
    wr(A_MSK, 32'd0);
    rd(A_MSK, "R8 mask cleared");

    // alarm
    wr(A_SEC, 32'd41);
    wr(A_ALM, 32'd42);
    rd(A_ALM, "R6 alarm readback");
    rd_exp(A_STA, 32'd0, "R6 status before match");
    wait_to(2 * EDGES_PER_S + 10);
    rd(A_SEC, "R6 seconds at alarm");
    rd_exp(A_STA, 32'd1, "R6 status set on match");
    @(negedge clk);
    chk("R8 irq masked", 32'(irq), 32'd0);
    wr(A_MSK, 32'd1);
    repeat (2) @(negedge clk);
    chk("R8 irq enabled", 32'(irq), 32'd1);
    wr(A_STA, 32'd0);
    rd_exp(A_STA, 32'd1, "R7 write zero keeps status");
    @(negedge clk);
    chk("R7 irq kept", 32'(irq), 32'd1);
    wr(A_STA, 32'h1f);
    rd_exp(A_STA, 32'd0, "R7 write one clears");
    repeat (20) @(negedge clk);
    rd_exp(A_STA, 32'd0, "R6 no reset while matching");
    chk("R8 irq cleared", 32'(irq), 32'd0);

    repeat (4) @(negedge clk);
    chk("R9 all reads returned", 32'(sb_q.size()), 32'd0);
    finish_run();
  end
endmodule